// File: doc/BRIEF.md
# Backplane Transfer Snapshot with Timeout Acknowledge

This block observes an asynchronous parallel backplane bus and records what each transfer looked like when it ended. Data, address, address-modifier and control lines are brought into the local clock domain, and the whole set is frozen into snapshot registers on the first acknowledge or bus-error strobe after the address strobe goes active. A second register keeps the eight arbitration grant-input lines as they stood when the bus-busy line went active.

When no slave answers, the block can stand in for one. If it is allowed to and is not in passive mode, it counts cycles from the address strobe. When the count reaches a programmable limit it pulls its own acknowledge output low, takes the snapshot and sets a sticky flag. A halt mode keeps the first snapshot taken after it is armed, and drives an indicator that blinks while armed and stays steady once frozen. Display formatting and the electrical bus drivers belong elsewhere.

Top module: `bus_snoop_capture`

## Requirements
- R1: Every bus input passes through two synchronizing flops. The snapshot holds the synchronized data, address and modifier lines plus a 9-bit control vector. Its bit order is: 0 address strobe, 1 data strobe 0, 2 data strobe 1, 3 write, 4 long-word, 5 acknowledge, 6 bus error, 7 interrupt acknowledge, 8 interrupt-acknowledge daisy input. All control bits are active low and stored as sampled.
- R2: While the address strobe is asserted, the first falling edge of either acknowledge or bus error latches the snapshot and raises `cap_pulse_o` for exactly one cycle.
- R3: With `subst_en_i` high and `passive_i` low, a substitute acknowledge fires when `timeout_i` is less than the number of clock cycles between the address strobe and the real acknowledge (or bus error) at the inputs, or when no answer comes. A tie goes to the real answer. A substitute latches the snapshot with both the acknowledge and bus-error bits high.
- R4: `subst_flag_o` goes high on a substitute acknowledge and stays high until `flag_clr_i`. A set in the same cycle wins over a clear.
- R5: `subst_dtack_n_o` goes low one cycle after a substitute fires and stays low until the synchronized address strobe deasserts. While `passive_i` is high it is never driven low.
- R6: Only one capture occurs per address-strobe cycle. An acknowledge or bus error after a substitute, or one seen while the address strobe is idle, changes nothing.
- R7: A falling edge of the synchronized bus-busy line copies the synchronized grant-input lines into `grant_o`. Grant changes while bus-busy stays low are ignored.
- R8: With `halt_en_i` high, the first capture freezes the snapshot and `grant_o` until `halt_en_i` drops. `halted_o` shows the frozen state.
- R9: `halt_ind_o` is low when halt is disabled. It toggles with a period of 2^`BLINK_W` cycles while armed and not yet frozen, and is steadily high when frozen.
- R10: The timeout counter restarts at zero in every address-strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_data_i | input | DATA_W | Raw data lines |
| bus_addr_i | input | ADDR_W | Raw address lines (upper 31) |
| bus_am_i | input | AM_W | Raw address-modifier lines |
| bus_ctrl_n_i | input | 9 | Raw control lines, order as in R1 |
| bbsy_n_i | input | 1 | Raw bus-busy line, active low |
| bgin_n_i | input | GNT_W | Raw grant-input lines |
| subst_en_i | input | 1 | Allow substitute acknowledge |
| passive_i | input | 1 | Never drive the bus |
| halt_en_i | input | 1 | Arm halt mode |
| flag_clr_i | input | 1 | Clear the substitute flag |
| timeout_i | input | TMO_W | Substitute acknowledge timeout in cycles |
| snap_data_o | output | DATA_W | Latched data |
| snap_addr_o | output | ADDR_W | Latched address |
| snap_am_o | output | AM_W | Latched address modifier |
| snap_ctrl_o | output | 9 | Latched control vector |
| cap_pulse_o | output | 1 | One-cycle pulse per capture |
| grant_o | output | GNT_W | Latched grant-input lines |
| subst_flag_o | output | 1 | Sticky substitute-acknowledge flag |
| subst_dtack_n_o | output | 1 | Substitute acknowledge drive, active low |
| halted_o | output | 1 | Snapshot frozen by halt |
| halt_ind_o | output | 1 | Halt indicator: blink or steady |

## Verification
The real acknowledge and the expiring timeout can land in the same cycle. That decides whether the block stands in for a slave that was in fact on time. The bench sweeps the timeout against the acknowledge delay, so every pairing comes up, including equal values where both events hit the same clock. For each pairing it judges the sticky flag, the drive output and the acknowledge bit of the snapshot: a tie must show a real acknowledge, and the drive must stay high.

// File: rtl/bsc_pkg.sv
// Shared widths and control-vector bit positions for the bus snapshot block.
package bsc_pkg;
    localparam int BSC_DATA_W = 32;
    localparam int BSC_ADDR_W = 31;
    localparam int BSC_AM_W   = 6;
    localparam int BSC_GNT_W  = 8;
    localparam int CTRL_W     = 9;
    // Control vector bit positions (active-low lines)
    localparam int CB_AS     = 0;
    localparam int CB_DS0    = 1;
    localparam int CB_DS1    = 2;
    localparam int CB_WRITE  = 3;
    localparam int CB_LWORD  = 4;
    localparam int CB_DTACK  = 5;
    localparam int CB_BERR   = 6;
    localparam int CB_IACK   = 7;
    localparam int CB_IACKIN = 8;
endpackage

// File: rtl/bsc_sync.sv
// Two-flop synchronizer for a vector of asynchronous lines.
// Assumes: lines are quasi-static around strobe edges; idle level is high.
module bsc_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;

    // Two-stage capture into the local clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '1;
            q_o    <= '1;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/bsc_ack_timer.sv
// Ends transfers: detects the real acknowledge or bus error, counts the
// timeout from address strobe and fires a substitute acknowledge.
// Assumes: inputs are synchronized; ack_fall_i is a one-cycle edge.
module bsc_ack_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             as_low_i,
    input  logic             ack_fall_i,
    input  logic [TMO_W-1:0] timeout_i,
    input  logic             subst_en_i,
    input  logic             passive_i,
    input  logic             flag_clr_i,
    output logic             end_evt_o,
    output logic             drive_n_o,
    output logic             flag_o
);
    logic [TMO_W-1:0] cnt_q;
    logic             done_q;
    logic             real_end;
    logic             fire;

    assign real_end  = as_low_i & ~done_q & ack_fall_i;
    assign fire      = as_low_i & ~done_q & ~ack_fall_i & subst_en_i
                       & ~passive_i & (cnt_q == timeout_i);
    assign end_evt_o = real_end | fire;

    // Cycles since address strobe, saturating, cleared when strobe is idle
    always_ff @(posedge clk) begin
        if (!rst_n || !as_low_i)  cnt_q <= '0;
        else if (cnt_q != '1)     cnt_q <= cnt_q + 1'b1;
    end

    // One end event per address-strobe cycle
    always_ff @(posedge clk) begin
        if (!rst_n || !as_low_i)  done_q <= 1'b0;
        else if (end_evt_o)       done_q <= 1'b1;
    end

    // Substitute drive held until the strobe releases; never in passive mode
    always_ff @(posedge clk) begin
        if (!rst_n || !as_low_i || passive_i) drive_n_o <= 1'b1;
        else if (fire)                        drive_n_o <= 1'b0;
    end

    // Sticky record of a substitute; set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_o <= 1'b0;
        else if (fire)       flag_o <= 1'b1;
        else if (flag_clr_i) flag_o <= 1'b0;
    end
endmodule

// File: rtl/bsc_capture.sv
// Snapshot and grant registers with halt freeze and the halt indicator.
// Assumes: write strobes are one-cycle events from synchronized lines.
module bsc_capture
    import bsc_pkg::*;
#(
    parameter int DATA_W  = BSC_DATA_W,
    parameter int ADDR_W  = BSC_ADDR_W,
    parameter int AM_W    = BSC_AM_W,
    parameter int GNT_W   = BSC_GNT_W,
    parameter int BLINK_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              end_evt_i,
    input  logic              bbsy_fall_i,
    input  logic              halt_en_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [AM_W-1:0]   am_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic [GNT_W-1:0]  gnt_i,
    output logic [DATA_W-1:0] data_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [AM_W-1:0]   am_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [GNT_W-1:0]  gnt_o,
    output logic              pulse_o,
    output logic              halted_o,
    output logic              ind_o
);
    logic               snap_we;
    logic               gnt_we;
    logic [BLINK_W-1:0] blink_q;

    assign snap_we = end_evt_i & ~halted_o;
    assign gnt_we  = bbsy_fall_i & ~halted_o;

    // Transfer snapshot and its capture pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o  <= '0;
            addr_o  <= '0;
            am_o    <= '0;
            ctrl_o  <= '0;
            pulse_o <= 1'b0;
        end else begin
            pulse_o <= snap_we;
            if (snap_we) begin
                data_o <= data_i;
                addr_o <= addr_i;
                am_o   <= am_i;
                ctrl_o <= ctrl_i;
            end
        end
    end

    // Grant lines at bus-busy assertion
    always_ff @(posedge clk) begin
        if (!rst_n)      gnt_o <= '0;
        else if (gnt_we) gnt_o <= gnt_i;
    end

    // Frozen after the first capture while halt is armed
    always_ff @(posedge clk) begin
        if (!rst_n || !halt_en_i) halted_o <= 1'b0;
        else if (snap_we)         halted_o <= 1'b1;
    end

    // Free-running blink divider
    always_ff @(posedge clk) begin
        if (!rst_n) blink_q <= '0;
        else        blink_q <= blink_q + 1'b1;
    end

    assign ind_o = halted_o | (halt_en_i & blink_q[BLINK_W-1]);
endmodule

// File: rtl/bus_snoop_capture.sv
// Top: synchronizes the bus, detects strobe edges and ties the timer and
// capture units together. Assumes bus lines are idle high and change
// well away from the strobes they qualify.
module bus_snoop_capture
    import bsc_pkg::*;
#(
    parameter int DATA_W  = BSC_DATA_W,
    parameter int ADDR_W  = BSC_ADDR_W,
    parameter int AM_W    = BSC_AM_W,
    parameter int GNT_W   = BSC_GNT_W,
    parameter int TMO_W   = 16,
    parameter int BLINK_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_data_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [AM_W-1:0]   bus_am_i,
    input  logic [CTRL_W-1:0] bus_ctrl_n_i,
    input  logic              bbsy_n_i,
    input  logic [GNT_W-1:0]  bgin_n_i,
    input  logic              subst_en_i,
    input  logic              passive_i,
    input  logic              halt_en_i,
    input  logic              flag_clr_i,
    input  logic [TMO_W-1:0]  timeout_i,
    output logic [DATA_W-1:0] snap_data_o,
    output logic [ADDR_W-1:0] snap_addr_o,
    output logic [AM_W-1:0]   snap_am_o,
    output logic [CTRL_W-1:0] snap_ctrl_o,
    output logic              cap_pulse_o,
    output logic [GNT_W-1:0]  grant_o,
    output logic              subst_flag_o,
    output logic              subst_dtack_n_o,
    output logic              halted_o,
    output logic              halt_ind_o
);
    localparam int SYNC_W = DATA_W + ADDR_W + AM_W + CTRL_W + 1 + GNT_W;

    logic [DATA_W-1:0] data_s;
    logic [ADDR_W-1:0] addr_s;
    logic [AM_W-1:0]   am_s;
    logic [CTRL_W-1:0] ctrl_s;
    logic              bbsy_s;
    logic [GNT_W-1:0]  gnt_s;
    logic              dtack_q, berr_q, bbsy_q;
    logic              ack_fall, bbsy_fall, end_evt;

    bsc_sync #(.W(SYNC_W)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({bus_data_i, bus_addr_i, bus_am_i, bus_ctrl_n_i, bbsy_n_i, bgin_n_i}),
        .q_o   ({data_s, addr_s, am_s, ctrl_s, bbsy_s, gnt_s})
    );

    // Previous synchronized strobe levels for falling-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dtack_q <= 1'b1;
            berr_q  <= 1'b1;
            bbsy_q  <= 1'b1;
        end else begin
            dtack_q <= ctrl_s[CB_DTACK];
            berr_q  <= ctrl_s[CB_BERR];
            bbsy_q  <= bbsy_s;
        end
    end

    assign ack_fall  = (dtack_q & ~ctrl_s[CB_DTACK]) | (berr_q & ~ctrl_s[CB_BERR]);
    assign bbsy_fall = bbsy_q & ~bbsy_s;

    bsc_ack_timer #(.TMO_W(TMO_W)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .as_low_i   (~ctrl_s[CB_AS]),
        .ack_fall_i (ack_fall),
        .timeout_i  (timeout_i),
        .subst_en_i (subst_en_i),
        .passive_i  (passive_i),
        .flag_clr_i (flag_clr_i),
        .end_evt_o  (end_evt),
        .drive_n_o  (subst_dtack_n_o),
        .flag_o     (subst_flag_o)
    );

    bsc_capture #(
        .DATA_W (DATA_W), .ADDR_W (ADDR_W), .AM_W (AM_W),
        .GNT_W  (GNT_W),  .BLINK_W(BLINK_W)
    ) cap_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .end_evt_i   (end_evt),
        .bbsy_fall_i (bbsy_fall),
        .halt_en_i   (halt_en_i),
        .data_i      (data_s),
        .addr_i      (addr_s),
        .am_i        (am_s),
        .ctrl_i      (ctrl_s),
        .gnt_i       (gnt_s),
        .data_o      (snap_data_o),
        .addr_o      (snap_addr_o),
        .am_o        (snap_am_o),
        .ctrl_o      (snap_ctrl_o),
        .gnt_o       (grant_o),
        .pulse_o     (cap_pulse_o),
        .halted_o    (halted_o),
        .ind_o       (halt_ind_o)
    );
endmodule

// File: rtl/bus_snoop_capture_chk.sv
// Property checker for bus_snoop_capture, attached by bind below.
module bus_snoop_capture_chk #(
    parameter int DATA_W = 32,
    parameter int GNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              passive_i,
    input logic              subst_en_i,
    input logic              flag_clr_i,
    input logic              halt_en_i,
    input logic [DATA_W-1:0] snap_data_o,
    input logic [GNT_W-1:0]  grant_o,
    input logic              cap_pulse_o,
    input logic              subst_flag_o,
    input logic              subst_dtack_n_o,
    input logic              halted_o,
    input logic              halt_ind_o
);
    a_r5_passive_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        passive_i |=> subst_dtack_n_o);

    a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (subst_flag_o && !flag_clr_i) |=> subst_flag_o);

    a_r3_drive_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(subst_dtack_n_o) |-> subst_flag_o);

    a_r3_drive_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(subst_dtack_n_o) |-> $past(subst_en_i));

    a_r6_single_capture: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse_o |=> !cap_pulse_o);

    a_r8_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && halt_en_i) |=> ($stable(snap_data_o) && $stable(grant_o)));

    a_r9_halt_steady: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |-> halt_ind_o);
endmodule

bind bus_snoop_capture bus_snoop_capture_chk #(.DATA_W(DATA_W), .GNT_W(GNT_W)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .passive_i       (passive_i),
    .subst_en_i      (subst_en_i),
    .flag_clr_i      (flag_clr_i),
    .halt_en_i       (halt_en_i),
    .snap_data_o     (snap_data_o),
    .grant_o         (grant_o),
    .cap_pulse_o     (cap_pulse_o),
    .subst_flag_o    (subst_flag_o),
    .subst_dtack_n_o (subst_dtack_n_o),
    .halted_o        (halted_o),
    .halt_ind_o      (halt_ind_o)
);

// File: tb/bus_snoop_capture_tb_top.sv
module bus_snoop_capture_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] data = '0;
    logic [30:0] addr = '0;
    logic [5:0]  am = '0;
    logic        as_n = 1'b1, ds_n = 1'b1, wr_n = 1'b1, lw_n = 1'b1;
    logic        dtack_n = 1'b1, berr_n = 1'b1;
    logic        bbsy_n = 1'b1;
    logic [7:0]  bgin_n = 8'hFF;
    logic        subst_en = 1'b0, passive = 1'b0, halt_en = 1'b0, flag_clr = 1'b0;
    logic [15:0] timeout = '0;

    logic [31:0] snap_data;
    logic [30:0] snap_addr;
    logic [5:0]  snap_am;
    logic [8:0]  snap_ctrl;
    logic        cap_pulse, subst_flag, drive_n, halted, halt_ind;
    logic [7:0]  grant;

    int checks = 0, errors = 0, cap_cnt = 0;
    logic [31:0] e_data = '0;
    logic [30:0] e_addr = '0;
    logic [5:0]  e_am = '0;
    logic [8:0]  e_ctrl = '0;

    always #4 clk = ~clk;

    bus_snoop_capture #(.BLINK_W(3)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_data_i(data), .bus_addr_i(addr), .bus_am_i(am),
        .bus_ctrl_n_i({1'b1, 1'b1, berr_n, dtack_n, lw_n, wr_n, ds_n, ds_n, as_n}),
        .bbsy_n_i(bbsy_n), .bgin_n_i(bgin_n),
        .subst_en_i(subst_en), .passive_i(passive), .halt_en_i(halt_en),
        .flag_clr_i(flag_clr), .timeout_i(timeout),
        .snap_data_o(snap_data), .snap_addr_o(snap_addr), .snap_am_o(snap_am),
        .snap_ctrl_o(snap_ctrl), .cap_pulse_o(cap_pulse), .grant_o(grant),
        .subst_flag_o(subst_flag), .subst_dtack_n_o(drive_n),
        .halted_o(halted), .halt_ind_o(halt_ind)
    );

    always @(negedge clk) if (rst_n && cap_pulse) cap_cnt++;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // kind: 0 acknowledge, 1 bus error, 2 no answer
    task automatic xfer(input int tmo, input int dly, input int kind,
                        input logic [31:0] dat, input logic [30:0] adr,
                        input logic [5:0] amv, input logic wr, input logic lw,
                        input bit frozen);
        bit sub, cap;
        int c0;
        sub = subst_en && !passive && (kind == 2 || tmo < dly);
        cap = (sub || kind != 2) && !frozen;
        @(negedge clk);
        c0 = cap_cnt;
        data = dat; addr = adr; am = amv; wr_n = wr; lw_n = lw;
        ds_n = 1'b0; as_n = 1'b0; timeout = 16'(tmo);
        repeat (dly) @(negedge clk);
        if (kind == 0) dtack_n = 1'b0;
        if (kind == 1) berr_n = 1'b0;
        repeat (tmo + 6) @(negedge clk);
        if (cap) begin
            e_data = dat; e_addr = adr; e_am = amv;
            // R1 bit order: iackin iack berr dtack lword write ds1 ds0 as
            e_ctrl = {1'b1, 1'b1, (!sub && kind == 1) ? 1'b0 : 1'b1,
                      (!sub && kind == 0) ? 1'b0 : 1'b1, lw, wr, 1'b0, 1'b0, 1'b0};
        end
        chk(snap_data == e_data, "R1 data", 64'(snap_data), 64'(e_data));
        chk(snap_addr == e_addr, "R1 addr", 64'(snap_addr), 64'(e_addr));
        chk(snap_am == e_am, "R1 am", 64'(snap_am), 64'(e_am));
        chk(snap_ctrl == e_ctrl, "R3 ctrl ack bits", 64'(snap_ctrl), 64'(e_ctrl));
        chk((cap_cnt - c0) == (cap ? 1 : 0), "R6 one capture per cycle",
            64'(cap_cnt - c0), 64'(cap ? 1 : 0));
        chk(subst_flag == sub, "R4 flag set", 64'(subst_flag), 64'(sub));
        chk(drive_n == !sub, "R5 drive while strobe", 64'(drive_n), 64'(!sub));
        as_n = 1'b1; ds_n = 1'b1; dtack_n = 1'b1; berr_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(drive_n == 1'b1, "R5 drive released", 64'(drive_n), 64'd1);
        if (sub) begin
            flag_clr = 1'b1;
            @(negedge clk);
            flag_clr = 1'b0;
            @(negedge clk);
            chk(subst_flag == 1'b0, "R4 flag cleared", 64'(subst_flag), 64'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=completion");
        finish_run();
    end

    initial begin
        bit seen0, seen1, steady;
        logic [31:0] fz_data;
        logic [7:0]  fz_gnt;
        int c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk(snap_data == 0 && snap_ctrl == 0, "R1 reset snapshot", 64'(snap_ctrl), 64'd0);
        chk(subst_flag == 0, "R4 reset flag", 64'(subst_flag), 64'd0);
        chk(drive_n == 1, "R5 reset drive", 64'(drive_n), 64'd1);
        chk(halt_ind == 0 && grant == 0, "R9 reset indicator", 64'(halt_ind), 64'd0);

        // R2 R3 R10: sweep timeout against answer delay, ties included
        subst_en = 1'b1;
        for (int t = 0; t < 5; t++)
            for (int d = 1; d < 7; d++)
                xfer(t, d, (t + d) % 3, 32'hA500_0000 ^ (32'(t) << 12) ^ 32'(d * 77),
                     31'h1234_0000 + 31'(t * 16 + d), 6'(t * 6 + d), 1'((t + d) & 1), 1'(d & 1), 1'b0);

        // R3 disabled: never substitutes
        subst_en = 1'b0;
        xfer(0, 4, 0, 32'h0BAD_F00D, 31'h55, 6'h3D, 1'b0, 1'b1, 1'b0);
        xfer(0, 4, 2, 32'h1111_2222, 31'h66, 6'h01, 1'b1, 1'b0, 1'b0);
        // R5 passive: never drives, no substitute capture
        subst_en = 1'b1; passive = 1'b1;
        xfer(0, 4, 1, 32'hCAFE_0001, 31'h77, 6'h2A, 1'b1, 1'b1, 1'b0);
        xfer(0, 4, 2, 32'hCAFE_0002, 31'h78, 6'h2B, 1'b0, 1'b0, 1'b0);
        passive = 1'b0;

        // R6: acknowledge with strobe idle is ignored
        c0 = cap_cnt;
        data = 32'hDEAD_BEEF;
        dtack_n = 1'b0;
        repeat (6) @(negedge clk);
        chk(cap_cnt == c0 && snap_data == e_data, "R6 ack without strobe",
            64'(snap_data), 64'(e_data));
        dtack_n = 1'b1;
        repeat (3) @(negedge clk);

        // R7: grant capture for each single grant low
        for (int p = 0; p < 8; p++) begin
            bgin_n = ~(8'h01 << p);
            repeat (3) @(negedge clk);
            bbsy_n = 1'b0;
            repeat (4) @(negedge clk);
            chk(grant == ~(8'h01 << p), "R7 grant latch", 64'(grant), 64'(~(8'h01 << p)));
            if (p == 7) begin
                bgin_n = 8'h00;
                repeat (4) @(negedge clk);
                chk(grant == 8'h7F, "R7 grant ignored while busy", 64'(grant), 64'h7F);
            end
            bbsy_n = 1'b1;
            repeat (3) @(negedge clk);
        end

        // R9: armed indicator blinks
        halt_en = 1'b1;
        seen0 = 0; seen1 = 0;
        repeat (16) begin
            @(negedge clk);
            if (halt_ind) seen1 = 1; else seen0 = 1;
        end
        chk(seen0 && seen1 && !halted, "R9 blink while armed", {62'd0, seen1, seen0}, 64'd3);
        // R8: first capture freezes
        xfer(3, 2, 0, 32'h600D_0001, 31'h101, 6'h11, 1'b0, 1'b0, 1'b0);
        chk(halted == 1'b1, "R8 halted after capture", 64'(halted), 64'd1);
        steady = 1;
        repeat (16) begin
            @(negedge clk);
            if (!halt_ind) steady = 0;
        end
        chk(steady, "R9 steady when frozen", 64'(steady), 64'd1);
        fz_data = snap_data; fz_gnt = grant;
        xfer(3, 2, 0, 32'h0BAD_0002, 31'h202, 6'h22, 1'b1, 1'b1, 1'b1);
        bgin_n = 8'hA5;
        repeat (3) @(negedge clk);
        bbsy_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(snap_data == fz_data && grant == fz_gnt, "R8 frozen snapshot and grant",
            {24'd0, grant, snap_data}, {24'd0, fz_gnt, fz_data});
        bbsy_n = 1'b1;
        halt_en = 1'b0;
        repeat (2) @(negedge clk);
        chk(!halted && !halt_ind, "R9 off when disabled", 64'(halt_ind), 64'd0);
        xfer(2, 5, 1, 32'h0F0F_3C3C, 31'h303, 6'h33, 1'b0, 1'b1, 1'b0);
        finish_run();
    end
endmodule